// File: doc/BRIEF.md
# Controller Command Responder

This block stands in for a game-controller peripheral on a serial peripheral bus. A decoded command arrives on a valid/ready input: a command code, the requester's source and destination addresses, and a port number. The block answers with a response frame streamed as 32-bit words on a valid/ready output. The frame opens with a header word. The payload words follow, and a last flag marks the final word of the frame.

The payload depends on the command. A device-information request returns the identification block from an internal constant ROM. An extended-information request returns that same block followed by a version block. A condition request returns the button state of the selected port. A reset request is acknowledged with a header alone. Any other code produces a header-only error frame with an end-of-list flag raised for the caller. The block captures one of several button snapshot inputs when it accepts the command, chosen by the port number.

Top module: `resp_responder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: A command is taken in on a cycle where `cmd_valid` and `cmd_ready` are both high. From the next cycle, `cmd_ready` stays low and `rsp_valid` stays high until the word flagged last has been handshaken. In the cycle after that, `rsp_valid` is 0 and `cmd_ready` is 1.
- R3: The header word carries four fields: the response code in bits 7:0, the request's source address in bits 15:8, the request's destination address in bits 23:16, and the payload word count in bits 31:24.
- R4: Command 1 returns response code 5 with 28 payload words from the identification ROM, in ascending order. Word 0 is 0x00000001. Word 1 is 0x000F06FE. Word k for 2 ≤ k ≤ 26 is 0x20202020 XOR k. Word 27 holds the maximum power figure (0x01F4) in bits 31:16 and the standby figure (0x01AE) in bits 15:0.
- R5: Command 2 returns response code 6 with 48 payload words. These are the 28 identification words of R4 followed by 20 version words, where version word j is 0x76657200 OR j.
- R6: Command 9 returns response code 8 with three payload words. The first is 0x00000001. The second is 0xFFFF in bits 31:16, the selected port's high button byte in bits 15:8 and its low button byte in bits 7:0. The third is 0xFFFFFFFF.
- R7: The port number (0 to 3) selects the 16-bit slice `btn_snap[16*port+15 : 16*port]`. That slice is captured when the command is accepted, and later changes of `btn_snap` have no effect on the reply.
- R8: Command 3 returns a header-only frame with response code 7 and a count of 0, flagged last.
- R9: Every other command code returns a header-only frame with response code 0xFC and a count of 0, flagged last, with `rsp_eol` high on that word. `rsp_eol` is 0 on every word of every other frame.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold their values into the next cycle.
- R11: `rsp_last` is high on exactly the final word of a frame, which is header word plus the header's payload count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_code | input | 8 | Command code |
| cmd_dst | input | 8 | Request destination address |
| cmd_src | input | 8 | Request source address |
| cmd_port | input | 2 | Port whose buttons feed a condition reply |
| btn_snap | input | 64 | Four 16-bit button snapshots, port 0 in the low bits |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_data | output | 32 | Response word |
| rsp_last | output | 1 | Final word of the frame |
| rsp_eol | output | 1 | Error frame: caller must end its command list |

## Verification
The bench builds the block with its default parameters: four ports, a 0x70-byte identification ROM and a 0x50-byte version ROM. At this size, every one of the 256 command codes can be driven in turn, with every ROM word checked against its arithmetic formula and every word position compared against the last flag. The output is stalled on a repeating pattern, so every frame length meets back-pressure at different word positions. The condition reply is swept over all four ports and several button patterns, with the inputs changed right after each command is accepted.

// File: rtl/resp_pkg.sv
package resp_pkg;

   typedef enum logic [2:0] {
      K_INFO,
      K_EXT,
      K_ACK,
      K_COND,
      K_ERR
   } frame_kind_e;

   localparam logic [7:0] CMD_INFO  = 8'd1;
   localparam logic [7:0] CMD_EXT   = 8'd2;
   localparam logic [7:0] CMD_RST   = 8'd3;
   localparam logic [7:0] CMD_COND  = 8'd9;

   localparam logic [7:0] RSP_INFO  = 8'd5;
   localparam logic [7:0] RSP_EXT   = 8'd6;
   localparam logic [7:0] RSP_ACK   = 8'd7;
   localparam logic [7:0] RSP_DATA  = 8'd8;
   localparam logic [7:0] RSP_ERR   = 8'hFC;

   localparam logic [31:0] FUNC_W0  = 32'h0000_0001;
   localparam logic [31:0] FUNC_W1  = 32'h000F_06FE;

   function automatic logic [31:0] id_filler(input int k);
      return 32'h2020_2020 ^ 32'(k);
   endfunction

   function automatic logic [31:0] ver_fill(input int j);
      return 32'h7665_7200 | 32'(j);
   endfunction

endpackage

// File: rtl/resp_decode.sv
module resp_decode
   import resp_pkg::*;
#(
   parameter int ID_WORDS  = 28,
   parameter int VER_WORDS = 20
) (
   input  logic [7:0]  code,
   output frame_kind_e kind,
   output logic [7:0]  rsp_code,
   output logic [7:0]  pay_len
);

   always_comb begin
      case (code)
         CMD_INFO: begin kind = K_INFO; rsp_code = RSP_INFO; pay_len = 8'(ID_WORDS);             end
         CMD_EXT:  begin kind = K_EXT;  rsp_code = RSP_EXT;  pay_len = 8'(ID_WORDS + VER_WORDS); end
         CMD_RST:  begin kind = K_ACK;  rsp_code = RSP_ACK;  pay_len = 8'd0;                     end
         CMD_COND: begin kind = K_COND; rsp_code = RSP_DATA; pay_len = 8'd3;                     end
         default:  begin kind = K_ERR;  rsp_code = RSP_ERR;  pay_len = 8'd0;                     end
      endcase
   end

endmodule

// File: rtl/resp_rom.sv
module resp_rom
   import resp_pkg::*;
#(
   parameter int          ID_WORDS  = 28,
   parameter int          VER_WORDS = 20,
   parameter int          ADDR_W    = 6,
   parameter logic [15:0] PWR_STBY  = 16'h01AE,
   parameter logic [15:0] PWR_MAX   = 16'h01F4
) (
   input  logic [ADDR_W-1:0] id_addr,
   input  logic [ADDR_W-1:0] ver_addr,
   output logic [31:0]       id_word,
   output logic [31:0]       ver_word
);

   logic [31:0] id_mem  [ID_WORDS];
   logic [31:0] ver_mem [VER_WORDS];

   for (genvar k = 0; k < ID_WORDS; k++) begin : g_id
      if (k == 0) begin : g_w0
         assign id_mem[k] = FUNC_W0;
      end else if (k == 1) begin : g_w1
         assign id_mem[k] = FUNC_W1;
      end else if (k == ID_WORDS - 1) begin : g_pwr
         assign id_mem[k] = {PWR_MAX, PWR_STBY};
      end else begin : g_fill
         assign id_mem[k] = id_filler(k);
      end
   end

   for (genvar j = 0; j < VER_WORDS; j++) begin : g_ver
      assign ver_mem[j] = ver_fill(j);
   end

   always_comb begin
      id_word = '0;
      for (int k = 0; k < ID_WORDS; k++)
         if (id_addr == ADDR_W'(k)) id_word = id_mem[k];
      ver_word = '0;
      for (int j = 0; j < VER_WORDS; j++)
         if (ver_addr == ADDR_W'(j)) ver_word = ver_mem[j];
   end

endmodule

// File: rtl/resp_seq.sv
module resp_seq #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   input  logic             out_ready,
   output logic             busy,
   output logic [CNT_W-1:0] idx,
   output logic             last
);

   logic [CNT_W-1:0] len_q;

   assign last = busy && (idx == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         len_q <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            len_q <= len;
         end
      end else if (out_ready) begin
         if (last) busy <= 1'b0;
         else      idx  <= idx + 1'b1;
      end
   end

endmodule

// File: rtl/resp_responder.sv
module resp_responder
   import resp_pkg::*;
#(
   parameter int          NUM_PORTS = 4,
   parameter int          BTN_W     = 16,
   parameter int          ID_BYTES  = 112,
   parameter int          VER_BYTES = 80,
   parameter logic [15:0] PWR_STBY  = 16'h01AE,
   parameter logic [15:0] PWR_MAX   = 16'h01F4,
   localparam int         PORT_W    = $clog2(NUM_PORTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   output logic                       cmd_ready,
   input  logic [7:0]                 cmd_code,
   input  logic [7:0]                 cmd_dst,
   input  logic [7:0]                 cmd_src,
   input  logic [PORT_W-1:0]          cmd_port,
   input  logic [NUM_PORTS*BTN_W-1:0] btn_snap,
   output logic                       rsp_valid,
   input  logic                       rsp_ready,
   output logic [31:0]                rsp_data,
   output logic                       rsp_last,
   output logic                       rsp_eol
);

   localparam int ID_WORDS  = ID_BYTES / 4;
   localparam int VER_WORDS = VER_BYTES / 4;
   localparam int MAX_LEN   = ID_WORDS + VER_WORDS;
   localparam int CNT_W     = $clog2(MAX_LEN + 2);

   if (ID_BYTES % 4 != 0 || VER_BYTES % 4 != 0 || ID_WORDS < 3 || VER_WORDS < 1) begin : g_bad_rom
      $error("resp_responder: ROM sizes must be whole words, at least 3 id and 1 version word");
   end
   if (MAX_LEN > 255) begin : g_bad_len
      $error("resp_responder: payload count must fit the 8-bit header field");
   end
   if (BTN_W != 16 || NUM_PORTS < 2) begin : g_bad_btn
      $error("resp_responder: button snapshots are two bytes wide, at least two ports");
   end

   logic [BTN_W-1:0] port_btn [NUM_PORTS];
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign port_btn[p] = btn_snap[p*BTN_W +: BTN_W];
   end

   frame_kind_e      dec_kind, kind_q;
   logic [7:0]       dec_code, dec_len;
   logic [7:0]       code_q, len_q, dst_q, src_q;
   logic [BTN_W-1:0] btn_q;
   logic             busy, last, accept;
   logic [CNT_W-1:0] idx, pidx;
   logic [31:0]      id_word, ver_word;

   resp_decode #(.ID_WORDS(ID_WORDS), .VER_WORDS(VER_WORDS)) u_dec (
      .code     (cmd_code),
      .kind     (dec_kind),
      .rsp_code (dec_code),
      .pay_len  (dec_len)
   );

   assign accept    = cmd_valid && !busy;
   assign cmd_ready = !busy;

   resp_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .len       (CNT_W'(dec_len)),
      .out_ready (rsp_ready),
      .busy      (busy),
      .idx       (idx),
      .last      (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= K_ACK;
         code_q <= '0;
         len_q  <= '0;
         dst_q  <= '0;
         src_q  <= '0;
         btn_q  <= '0;
      end else if (accept) begin
         kind_q <= dec_kind;
         code_q <= dec_code;
         len_q  <= dec_len;
         dst_q  <= cmd_dst;
         src_q  <= cmd_src;
         btn_q  <= port_btn[cmd_port];
      end
   end

   assign pidx = idx - 1'b1;

   resp_rom #(
      .ID_WORDS (ID_WORDS),
      .VER_WORDS(VER_WORDS),
      .ADDR_W   (CNT_W),
      .PWR_STBY (PWR_STBY),
      .PWR_MAX  (PWR_MAX)
   ) u_rom (
      .id_addr  (pidx),
      .ver_addr (pidx - CNT_W'(ID_WORDS)),
      .id_word  (id_word),
      .ver_word (ver_word)
   );

   always_comb begin
      if (idx == '0) begin
         rsp_data = {len_q, dst_q, src_q, code_q};
      end else begin
         case (kind_q)
            K_INFO:  rsp_data = id_word;
            K_EXT:   rsp_data = (pidx < CNT_W'(ID_WORDS)) ? id_word : ver_word;
            K_COND: begin
               if (pidx == '0)      rsp_data = FUNC_W0;
               else if (pidx == 1)  rsp_data = {16'hFFFF, btn_q[15:8], btn_q[7:0]};
               else                 rsp_data = 32'hFFFF_FFFF;
            end
            default: rsp_data = '0;
         endcase
      end
   end

   assign rsp_valid = busy;
   assign rsp_last  = last;
   assign rsp_eol   = busy && (kind_q == K_ERR);

endmodule

// File: rtl/resp_checker.sv
module resp_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic [7:0]  cmd_code,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [31:0] rsp_data,
   input logic        rsp_last,
   input logic        rsp_eol
);

   logic       mid;
   logic [8:0] beats;
   logic [7:0] hdr_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mid     <= 1'b0;
         beats   <= '0;
         hdr_len <= '0;
      end else if (rsp_valid && rsp_ready) begin
         if (rsp_last) begin
            mid <= 1'b0;
         end else if (!mid) begin
            mid     <= 1'b1;
            beats   <= 9'd1;
            hdr_len <= rsp_data[31:24];
         end else begin
            beats <= beats + 9'd1;
         end
      end
   end

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> rsp_valid && !cmd_ready);

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ready && rsp_last |=> !rsp_valid && cmd_ready);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));

   p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_last && mid |-> beats == {1'b0, hdr_len});

   p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_last && !mid |-> rsp_data[31:24] == 8'd0);

   p_eol_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_eol |-> rsp_valid && rsp_last && rsp_data[7:0] == 8'hFC);

   p_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_code == 8'd9 |=> rsp_data[7:0] == 8'h08 && rsp_data[31:24] == 8'd3);

endmodule

bind resp_responder resp_checker u_chk (.*);

// File: tb/tb_resp_responder.sv
module tb_resp_responder;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_code = '0, cmd_dst = '0, cmd_src = '0;
   logic [1:0]  cmd_port = '0;
   logic [63:0] btn_snap = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_data;
   logic        rsp_last, rsp_eol;

   int checks = 0;
   int fails  = 0;
   int phase  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   resp_responder dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_code(cmd_code), .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_port(cmd_port),
      .btn_snap(btn_snap), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_eol(rsp_eol)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic int exp_len(input logic [7:0] c);
      case (c)
         8'd1:    return 28;
         8'd2:    return 48;
         8'd9:    return 3;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] exp_code(input logic [7:0] c);
      case (c)
         8'd1:    return 8'd5;
         8'd2:    return 8'd6;
         8'd3:    return 8'd7;
         8'd9:    return 8'd8;
         default: return 8'hFC;
      endcase
   endfunction

   function automatic logic [31:0] id_w(input int k);
      if (k == 0)  return 32'h1;
      if (k == 1)  return 32'h000F06FE;
      if (k == 27) return 32'h01F4_01AE;
      return 32'h20202020 ^ 32'(k);
   endfunction

   function automatic logic [31:0] ver_w(input int j);
      return 32'h76657200 | 32'(j);
   endfunction

   task automatic run_cmd(input logic [7:0] code, input logic [7:0] dst, input logic [7:0] src,
                          input logic [1:0] port, input logic [63:0] btns);
      logic [15:0] cap;
      logic [31:0] e, prev_d;
      logic        prev_l;
      bit          stall, done;
      int          idx, n;
      string       tag;
      @(negedge clk);
      chk(cmd_ready === 1'b1, "R2 ready before command", {31'b0, cmd_ready}, 32'h1);
      cmd_code = code; cmd_dst = dst; cmd_src = src; cmd_port = port; btn_snap = btns;
      cmd_valid = 1'b1;
      cap = btns[16*port +: 16];
      @(negedge clk);
      cmd_valid = 1'b0;
      btn_snap  = ~btns;
      n = exp_len(code);
      case (code)
         8'd1: tag = "R4"; 8'd2: tag = "R5"; 8'd9: tag = "R6 R7"; 8'd3: tag = "R8";
         default: tag = "R9";
      endcase
      idx = 0; done = 0; stall = 0; prev_d = '0; prev_l = 0;
      while (!done) begin
         if (stall)
            chk(rsp_valid && rsp_data === prev_d && rsp_last === prev_l, "R10 hold under stall", rsp_data, prev_d);
         rsp_ready = (phase % 3) != 1;
         phase++;
         if (!rsp_valid) begin
            chk(0, "R2 valid dropped mid-frame", {31'b0, rsp_valid}, 32'h1);
            done = 1;
         end else if (rsp_ready) begin
            if (idx == 0) begin
               e = {8'(n), dst, src, exp_code(code)};
               chk(rsp_data === e, "R3 header", rsp_data, e);
            end else begin
               case (code)
                  8'd1: e = id_w(idx - 1);
                  8'd2: e = (idx - 1 < 28) ? id_w(idx - 1) : ver_w(idx - 29);
                  default: e = (idx == 1) ? 32'h1 : (idx == 2) ? {16'hFFFF, cap} : 32'hFFFFFFFF;
               endcase
               chk(rsp_data === e, tag, rsp_data, e);
            end
            chk(rsp_last === (idx == n), "R11 last flag", {31'b0, rsp_last}, {31'b0, idx == n});
            chk(rsp_eol === (exp_code(code) == 8'hFC), "R9 end-of-list flag", {31'b0, rsp_eol},
                {31'b0, exp_code(code) == 8'hFC});
            if (rsp_last || idx > 60) done = 1;
            idx++;
         end
         stall  = rsp_valid && !rsp_ready;
         prev_d = rsp_data;
         prev_l = rsp_last;
         @(negedge clk);
      end
      rsp_ready = 1'b0;
      chk(!rsp_valid && cmd_ready, "R2 idle after frame", {30'b0, rsp_valid, cmd_ready}, 32'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rsp_valid === 1'b0 && cmd_ready === 1'b1, "R1 in reset", {30'b0, rsp_valid, cmd_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0 && cmd_ready === 1'b1, "R1 after reset", {30'b0, rsp_valid, cmd_ready}, 32'h1);
      for (int c = 0; c < 256; c++)
         run_cmd(8'(c), 8'(c) ^ 8'h5A, ~8'(c), 2'(c),
                 {16'(c * 7 + 3), 16'(c * 13 + 5), 16'(c ^ 16'hA55A), 16'(c * 257)});
      for (int p = 0; p < 4; p++) begin
         run_cmd(8'd9, 8'h20, 8'h01, 2'(p), 64'h0);
         run_cmd(8'd9, 8'h20, 8'h01, 2'(p), 64'hFFFF_FFFF_FFFF_FFFF);
         run_cmd(8'd9, 8'h20, 8'h01, 2'(p), 64'h00FF_FF00_0F0F_F0F0);
         run_cmd(8'd9, 8'h20, 8'h01, 2'(p), 64'h1234_5678_9ABC_DEF0);
      end
      summary();
      $finish;
   end

endmodule